// File: doc/BRIEF.md
# Sync-Hunt Capture Controller for a Delta-Modulated Bit Stream

This controller begins a recording from a single-bit delta-modulated audio stream. A start command makes it drive the encoder's force-idle input, which makes the encoder send its alternating silence pattern. While force-idle is held, the controller compares the most recent eight received bits against a programmable sync character on every bit strobe, at any bit alignment. The stream carries no framing of its own, so the first match sets the byte boundary for all audio that follows.

When the sync character is found, force-idle is released and the controller starts to assemble the following bits into bytes, with the first-received bit in the LSB. Each complete byte is handed to the host with a ready flag that stays set until the host acknowledges it. A byte that completes before the previous one was taken overwrites it and raises a sticky overrun flag. Because the sync character is programmable, a chosen bit pattern in the waveform can also serve as the capture trigger.

Top module: `sync_capture_ctrl`

## Requirements
- R1: After reset, force_idle, hunting, capturing, byte_rdy and overrun are all low and byte_data is zero.
- R2: A start_cmd without stop_cmd sets force_idle and hunting in the next cycle and clears byte_rdy and overrun.
- R3: While hunting, each bit strobe appends bit_in to a history of the bits strobed since the last start. A match needs at least 8 bits in that history, with the last 8 equal to sync_char when the oldest of the 8 is placed at bit 0. Cycles without a strobe add nothing to the history, and bits received while idle are ignored.
- R4: On the strobe that completes a match, force_idle drops and capturing rises in the next cycle. hunting and capturing are never high together.
- R5: In capture, the first bit strobed after the match is byte bit 0 and the eighth is bit 7. byte_rdy and byte_data update in the cycle after the eighth strobe.
- R6: byte_rdy and byte_data hold until byte_ack is seen while byte_rdy is high, and byte_rdy is clear in the following cycle. byte_ack while byte_rdy is low has no effect.
- R7: If a byte completes while byte_rdy is high and byte_ack is low in that cycle, overrun is set and stays set until the next start, and the new byte replaces the old one. A byte completing together with byte_ack sets no overrun.
- R8: stop_cmd returns the controller to idle in the next cycle, with force_idle, hunting and capturing low. It takes priority over start_cmd and leaves byte_rdy and byte_data as they were.
- R9: A start_cmd while hunting or capturing restarts the hunt with an empty bit history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Serial data bit from the modulator |
| bit_stb | input | 1 | One-cycle strobe marking bit_in as valid |
| start_cmd | input | 1 | Begin a capture (start hunting) |
| stop_cmd | input | 1 | Abort and return to idle |
| sync_char | input | CHAR_W | Character to hunt for |
| byte_ack | input | 1 | Host has taken byte_data |
| force_idle | output | 1 | Drives the encoder into its idle pattern |
| byte_data | output | CHAR_W | Last assembled byte |
| byte_rdy | output | 1 | byte_data holds an unacknowledged byte |
| overrun | output | 1 | Sticky: a byte was overwritten before acknowledge |
| hunting | output | 1 | Searching for the sync character |
| capturing | output | 1 | Assembling bytes after sync |

## Verification
The bench makes the sync character appear inside the first seven bits after start, so it can catch a design that matches on stale history or on a partly filled window. Such a design would release force-idle too early. The bench also sends the sync pattern with the bits reversed, which would pass on a design that packs MSB-first and wrongly drop force-idle. It completes a byte in the same cycle as an acknowledge, where a wrong ordering would either lose the new byte or raise a false overrun. It also issues stop and start together, and start during capture, where a wrong priority would leave the encoder forced idle or keep the stale byte alignment.

// File: rtl/sync_capture_pkg.sv
package sync_capture_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_HUNT = 2'd1,
    CAP_TAKE = 2'd2
  } cap_mode_e;
endpackage

// File: rtl/sync_hunter.sv
module sync_hunter #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              enable,
  input  logic              bit_stb,
  input  logic              bit_in,
  input  logic [CHAR_W-1:0] sync_char,
  output logic              match
);
  localparam int FILL_W = $clog2(CHAR_W + 1);

  // newest bit enters at the top, so the oldest of the window sits at bit 0
  function automatic logic [CHAR_W-1:0] push_window(input logic [CHAR_W-1:0] cur,
                                                    input logic b);
    return {b, cur[CHAR_W-1:1]};
  endfunction

  logic [CHAR_W-1:0] window_q;
  logic [CHAR_W-1:0] window_n;
  logic [FILL_W-1:0] fill_q;
  logic              full_after;

  assign window_n   = push_window(window_q, bit_in);
  assign full_after = (fill_q >= FILL_W'(CHAR_W - 1));
  assign match      = enable && bit_stb && full_after && (window_n == sync_char);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window_q <= '0;
      fill_q   <= '0;
    end else if (clear) begin
      window_q <= '0;
      fill_q   <= '0;
    end else if (enable && bit_stb) begin
      window_q <= window_n;
      if (fill_q != FILL_W'(CHAR_W)) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/byte_assembler.sv
module byte_assembler #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              enable,
  input  logic              bit_stb,
  input  logic              bit_in,
  output logic              done,
  output logic [CHAR_W-1:0] word
);
  localparam int CNT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;

  // after CHAR_W pushes, the first pushed bit has moved down to bit 0
  function automatic logic [CHAR_W-1:0] push_lsb_first(input logic [CHAR_W-1:0] cur,
                                                       input logic b);
    return {b, cur[CHAR_W-1:1]};
  endfunction

  logic [CNT_W-1:0]  cnt_q;
  logic [CHAR_W-1:0] acc_q;

  assign word = push_lsb_first(acc_q, bit_in);
  assign done = enable && bit_stb && (cnt_q == CNT_W'(CHAR_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (enable && bit_stb) begin
      acc_q <= word;
      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/byte_handoff.sv
module byte_handoff #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              done,
  input  logic [CHAR_W-1:0] word,
  input  logic              ack,
  output logic [CHAR_W-1:0] data,
  output logic              rdy,
  output logic              ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      rdy  <= 1'b0;
      ovr  <= 1'b0;
    end else if (clear) begin
      rdy <= 1'b0;
      ovr <= 1'b0;
    end else if (done) begin
      data <= word;
      rdy  <= 1'b1;
      if (rdy && !ack) ovr <= 1'b1;
    end else if (ack) begin
      rdy <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_capture_ctrl.sv
module sync_capture_ctrl #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_stb,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  input  logic [CHAR_W-1:0] sync_char,
  input  logic              byte_ack,
  output logic              force_idle,
  output logic [CHAR_W-1:0] byte_data,
  output logic              byte_rdy,
  output logic              overrun,
  output logic              hunting,
  output logic              capturing
);
  import sync_capture_pkg::*;

  cap_mode_e         mode_q;
  logic              cmd_quiet;
  logic              hunt_en;
  logic              take_en;
  logic              hunt_match;
  logic              byte_done;
  logic              restart_asm;
  logic              start_only;
  logic [CHAR_W-1:0] asm_word;

  assign cmd_quiet   = !start_cmd && !stop_cmd;
  assign hunt_en     = (mode_q == CAP_HUNT) && cmd_quiet;
  assign take_en     = (mode_q == CAP_TAKE) && cmd_quiet;
  assign start_only  = start_cmd && !stop_cmd;
  assign restart_asm = hunt_match || start_cmd || stop_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= CAP_IDLE;
    else if (stop_cmd)   mode_q <= CAP_IDLE;
    else if (start_cmd)  mode_q <= CAP_HUNT;
    else if (hunt_match) mode_q <= CAP_TAKE;
  end

  assign force_idle = (mode_q == CAP_HUNT);
  assign hunting    = (mode_q == CAP_HUNT);
  assign capturing  = (mode_q == CAP_TAKE);

  sync_hunter #(.CHAR_W(CHAR_W)) u_hunter (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_cmd),
    .enable    (hunt_en),
    .bit_stb   (bit_stb),
    .bit_in    (bit_in),
    .sync_char (sync_char),
    .match     (hunt_match)
  );

  byte_assembler #(.CHAR_W(CHAR_W)) u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart_asm),
    .enable  (take_en),
    .bit_stb (bit_stb),
    .bit_in  (bit_in),
    .done    (byte_done),
    .word    (asm_word)
  );

  byte_handoff #(.CHAR_W(CHAR_W)) u_handoff (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_only),
    .done  (byte_done),
    .word  (asm_word),
    .ack   (byte_ack),
    .data  (byte_data),
    .rdy   (byte_rdy),
    .ovr   (overrun)
  );
endmodule

// File: rtl/sync_capture_ctrl_chk.sv
module sync_capture_ctrl_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_cmd,
  input logic              stop_cmd,
  input logic              byte_ack,
  input logic              hunt_match,
  input logic              byte_done,
  input logic              force_idle,
  input logic              hunting,
  input logic              capturing,
  input logic              byte_rdy,
  input logic [CHAR_W-1:0] byte_data,
  input logic              overrun
);
  p_start_hunts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd && !stop_cmd |=> force_idle && hunting && !byte_rdy && !overrun);

  p_match_in_hunt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_match |-> hunting);

  p_match_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_match |=> !force_idle && capturing);

  p_one_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hunting && capturing));

  p_done_presents_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> byte_rdy);

  p_done_in_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> capturing);

  p_rdy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rdy && !byte_ack && !start_cmd && !byte_done |=> byte_rdy && $stable(byte_data));

  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !start_cmd |=> overrun);

  p_stop_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> !force_idle && !hunting && !capturing);
endmodule

bind sync_capture_ctrl sync_capture_ctrl_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_cmd  (start_cmd),
  .stop_cmd   (stop_cmd),
  .byte_ack   (byte_ack),
  .hunt_match (hunt_match),
  .byte_done  (byte_done),
  .force_idle (force_idle),
  .hunting    (hunting),
  .capturing  (capturing),
  .byte_rdy   (byte_rdy),
  .byte_data  (byte_data),
  .overrun    (overrun)
);

// File: tb/test_sync_capture_ctrl.sv
module test_sync_capture_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_in = 1'b0;
  logic       bit_stb = 1'b0;
  logic       start_cmd = 1'b0;
  logic       stop_cmd = 1'b0;
  logic [7:0] sync_char = 8'h00;
  logic       byte_ack = 1'b0;
  logic       force_idle;
  logic [7:0] byte_data;
  logic       byte_rdy;
  logic       overrun;
  logic       hunting;
  logic       capturing;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sync_capture_ctrl i_sync_capture_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_stb(bit_stb),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd), .sync_char(sync_char),
    .byte_ack(byte_ack), .force_idle(force_idle), .byte_data(byte_data),
    .byte_rdy(byte_rdy), .overrun(overrun), .hunting(hunting),
    .capturing(capturing)
  );

  // behavioural reference: 0 idle, 1 hunt, 2 capture
  int         m_mode;
  bit         hist[$];
  int         m_cnt;
  logic [7:0] m_acc;
  logic [7:0] m_data;
  logic       m_rdy;
  logic       m_ovr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; hist.delete(); m_cnt = 0; m_acc = 0;
      m_data = 0; m_rdy = 0; m_ovr = 0;
    end else begin
      bit done;
      bit ackd;
      logic [7:0] v;
      done = 1'b0;
      ackd = byte_ack && m_rdy;
      if (stop_cmd) m_mode = 0;
      else if (start_cmd) begin m_mode = 1; hist.delete(); end
      else if (bit_stb) begin
        if (m_mode == 1) begin
          hist.push_back(bit_in);
          if (hist.size() > 8) void'(hist.pop_front());
          if (hist.size() == 8) begin
            v = 0;
            foreach (hist[i]) v[i] = hist[i];
            if (v == sync_char) begin m_mode = 2; m_cnt = 0; m_acc = 0; end
          end
        end else if (m_mode == 2) begin
          m_acc[m_cnt] = bit_in;
          m_cnt++;
          if (m_cnt == 8) begin done = 1'b1; m_cnt = 0; end
        end
      end
      if (start_cmd && !stop_cmd) begin m_rdy = 0; m_ovr = 0; end
      else if (done) begin
        if (m_rdy && !ackd) m_ovr = 1;
        m_data = m_acc; m_rdy = 1; m_acc = 0;
      end else if (ackd) m_rdy = 0;
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%h expected=%h", req, what, $time, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk("R2", "force_idle", {7'd0, force_idle}, {7'd0, m_mode == 1});
    chk("R3", "hunting",    {7'd0, hunting},    {7'd0, m_mode == 1});
    chk("R4", "capturing",  {7'd0, capturing},  {7'd0, m_mode == 2});
    chk("R5", "byte_data",  byte_data, m_data);
    chk("R6", "byte_rdy",   {7'd0, byte_rdy},   {7'd0, m_rdy});
    chk("R7", "overrun",    {7'd0, overrun},    {7'd0, m_ovr});
  endtask

  task automatic send_bit(input logic b, input int gap, input logic ack);
    bit_in = b; bit_stb = 1'b1; byte_ack = ack;
    cyc();
    bit_stb = 1'b0; byte_ack = 1'b0; bit_in = ~b;
    repeat (gap) cyc();
  endtask

  task automatic send_byte(input logic [7:0] v, input int gap, input logic ack_last);
    for (int i = 0; i < 8; i++) send_bit(v[i], gap, ack_last && (i == 7));
  endtask

  task automatic pulse_start();
    start_cmd = 1'b1; cyc(); start_cmd = 1'b0;
  endtask

  task automatic pulse_ack();
    byte_ack = 1'b1; cyc(); byte_ack = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "force_idle", {7'd0, force_idle}, 8'd0);
    chk("R1", "byte_rdy",   {7'd0, byte_rdy},   8'd0);
    chk("R1", "byte_data",  byte_data,          8'd0);
    rst_n = 1'b1;
    cyc();
    chk("R1", "status", {6'd0, hunting, capturing}, 8'd0);

    // R3: bits while idle are ignored
    sync_char = 8'hA7;
    send_byte(8'hA7, 0, 1'b0);
    send_byte(8'hA7, 1, 1'b0);

    // R2, R3, R4: hunt through idle pattern, then sync
    pulse_start();
    for (int i = 0; i < 6; i++) send_bit(i[0], 1, 1'b0);
    send_byte(8'hE5, 2, 1'b0);   // bit-reversed sync must not match (R3)
    send_byte(8'hA7, 2, 1'b0);   // match (R4)
    // R5, R6: bytes with acknowledge
    send_byte(8'h3C, 1, 1'b0);
    repeat (3) cyc();
    pulse_ack();
    pulse_ack();                 // R6: ack with rdy low
    send_byte(8'h81, 0, 1'b0);
    send_byte(8'h5A, 0, 1'b1);   // R7: completes with ack, no overrun
    send_byte(8'hC3, 3, 1'b0);   // R7: overrun, overwrite
    repeat (2) cyc();
    pulse_ack();
    send_byte(8'h0F, 0, 1'b0);
    // R8: stop during capture keeps the byte
    stop_cmd = 1'b1; cyc(); stop_cmd = 1'b0;
    send_byte(8'hFF, 0, 1'b0);
    pulse_ack();

    // R3: partial window must not match a zero sync character
    sync_char = 8'h00;
    send_byte(8'h00, 0, 1'b0);
    pulse_start();
    for (int i = 0; i < 7; i++) send_bit(1'b0, 1, 1'b0);
    send_bit(1'b0, 1, 1'b0);     // eighth zero matches
    send_byte(8'h96, 0, 1'b0);
    // R9: start during capture restarts hunt
    send_bit(1'b1, 0, 1'b0);
    send_bit(1'b1, 0, 1'b0);
    pulse_start();
    for (int i = 0; i < 5; i++) send_bit(1'b0, 0, 1'b0);
    // R9: start during hunt clears history
    pulse_start();
    for (int i = 0; i < 7; i++) send_bit(1'b0, 0, 1'b0);
    // R8: stop and start together, stop wins
    stop_cmd = 1'b1; start_cmd = 1'b1; cyc(); stop_cmd = 1'b0; start_cmd = 1'b0;
    send_byte(8'h00, 0, 1'b0);
    // stop while hunting
    pulse_start();
    send_bit(1'b0, 0, 1'b0);
    stop_cmd = 1'b1; cyc(); stop_cmd = 1'b0;
    repeat (4) cyc();

    // sync embedded at odd alignment in a waveform pattern
    sync_char = 8'h6D;
    pulse_start();
    send_byte(8'h33, 0, 1'b0);
    send_bit(1'b1, 0, 1'b0);
    send_byte(8'h6D, 1, 1'b0);
    send_byte(8'h12, 0, 1'b1);
    send_byte(8'hED, 0, 1'b0);
    repeat (3) cyc();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule